// File: doc/BRIEF.md
# Register-Driven Serial EEPROM Model

This block behaves like a small serial EEPROM of 256 words of 16 bits each. Unlike a real device, it is driven entirely by software. A processor writes a single byte-wide control register to set the select, clock and data-in lines. Reading the same register returns the device's data-out line. The block holds the previous select and clock levels, so it sees edges only between two successive register writes. No real serial clock exists.

A rising select edge frames each transaction. A start bit follows, then a 2-bit opcode and an 8-bit address. Opcode 0 is an extended group selected by the two upper address bits: write-disable, write-enable, write-all and erase-all. The other opcodes are write (1), read (2) and erase (3).

Write-type transactions only stage their data. The stored words change on the next rising select edge, and only if writes are enabled. A read returns a dummy zero and then the word, most significant bit first. The word shifts out on falling clock edges.

Top module: `serprom_emu`

## Requirements
- R1: A register write sets select from bit 7, clock from bit 6 and data-in from bit 1. The read value `rd_data` carries data-out in bit 0, and its bits 7 to 1 are always zero.
- R2: After reset, writes are disabled, every word reads 0xFFFF, and data-out is 1.
- R3: A rising select edge puts the machine in idle. In idle, a rising clock edge with data-in 0 is ignored. A rising clock edge with data-in 1 is the start bit.
- R4: Opcode 0 with address bits 7:6 = 11 enables writes at once. Opcode 0 with address bits 7:6 = 00 disables writes at once.
- R5: Opcode 1 takes 16 data bits, most significant first. The addressed word takes that value on the next rising select edge, if writes are enabled.
- R6: Opcode 2 needs one extra clock after the address. Data-out then shows a dummy 0. Each later falling clock edge shifts out the next word bit, most significant first. After 16 bits the machine stops and data-out holds the last bit.
- R7: Opcode 3 takes 16 ignored bits. The addressed word becomes 0xFFFF on the next rising select edge, if writes are enabled.
- R8: Opcode 0 with address bits 7:6 = 01 takes 16 data bits and writes that value to every word, if writes are enabled.
- R9: Opcode 0 with address bits 7:6 = 10 takes 16 ignored bits and sets every word to 0xFFFF, if writes are enabled.
- R10: While writes are disabled, write, erase, write-all and erase-all leave every word unchanged.
- R11: A rising select edge in any state other than a staged write abandons the transaction without changing any word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One-cycle strobe of a control register write |
| wr_data | input | 8 | Control byte: bit 7 select, bit 6 clock, bit 1 data-in |
| rd_data | output | 8 | Register read value: bit 0 data-out, rest zero |

## Verification
The assertions assume that state changes only on cycles with a write strobe. They also assume that one register write can raise select and clock together, and that select processing then comes before clock processing. The bench never raises both in one write. Every transaction opens with a write that drops select and a write that raises it. Data-in is set with clock low before clock is raised, so each clock edge is alone in its write. This keeps the stimulus inside the single-edge cases that the properties name. The sweeps write and read every address, and the fill and erase commands are checked at strided addresses.

// File: rtl/serprom_emu.sv
module serprom_emu #(
  parameter int AW     = 8,
  parameter int DW     = 16,
  parameter int CS_BIT = 7,
  parameter int SK_BIT = 6,
  parameter int DI_BIT = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data
);
  localparam int WORDS = 1 << AW;
  localparam int SW    = DW + 1;
  localparam int CW    = $clog2(DW + 1);

  typedef enum logic [3:0] {
    S_NULL, S_IDLE, S_CMD, S_ADDR, S_EXT, S_WRD, S_RDD, S_ERD, S_READ, S_WRITE
  } st_t;

  logic [DW-1:0] mem [WORDS];
  st_t           st, st_n;
  logic [SW-1:0] sr, sr_n;
  logic [CW-1:0] cnt, cnt_n;
  logic [1:0]    op, op_n;
  logic [AW-1:0] adr, adr_n;
  logic          wen, wen_n;
  logic          cs_q, sk_q;
  logic          fill_all, clr_all, commit;

  wire cs_in   = wr_data[CS_BIT];
  wire sk_in   = wr_data[SK_BIT];
  wire di      = wr_data[DI_BIT];
  wire cs_rise = wr_en && cs_in && !cs_q;
  wire sk_rise = wr_en && sk_in && !sk_q;
  wire sk_fall = wr_en && !sk_in && sk_q;

  assign rd_data = 8'(sr[SW-1]);

  always_comb begin
    st_n = st; sr_n = sr; cnt_n = cnt; op_n = op; adr_n = adr; wen_n = wen;
    fill_all = 1'b0; clr_all = 1'b0; commit = 1'b0;
    if (cs_rise) begin
      if (st == S_WRITE) begin
        commit = wen;
        sr_n   = '1;
        st_n   = S_NULL;
      end else begin
        st_n = S_IDLE;
      end
    end
    if (sk_rise) begin
      if (st_n != S_NULL && st_n != S_IDLE && st_n != S_READ) begin
        sr_n  = {sr_n[SW-2:0], di};
        cnt_n = cnt_n + 1'b1;
      end
      case (st_n)
        S_IDLE: if (di) begin
          st_n = S_CMD; sr_n = '0; cnt_n = '0;
        end
        S_CMD: if (cnt_n == CW'(2)) begin
          op_n = sr_n[1:0]; cnt_n = '0; st_n = S_ADDR;
        end
        S_ADDR: if (cnt_n == CW'(AW)) begin
          adr_n = sr_n[AW-1:0];
          cnt_n = '0;
          case (op_n)
            2'd0: begin
              if (adr_n[AW-1:AW-2] == 2'b00) begin
                wen_n = 1'b0; st_n = S_NULL;
              end else if (adr_n[AW-1:AW-2] == 2'b11) begin
                wen_n = 1'b1; st_n = S_NULL;
              end else begin
                st_n = S_EXT;
              end
            end
            2'd1:    st_n = S_WRD;
            2'd2:    st_n = S_RDD;
            default: st_n = S_ERD;
          endcase
        end
        S_EXT: if (cnt_n == CW'(DW)) begin
          cnt_n = '0;
          st_n  = S_WRITE;
          if (adr_n[AW-1]) begin
            clr_all = wen;
            sr_n    = {1'b0, {DW{1'b1}}};
          end else begin
            fill_all = wen;
          end
        end
        S_WRD: if (cnt_n == CW'(DW)) begin
          cnt_n = '0; st_n = S_WRITE;
        end
        S_RDD: if (cnt_n == CW'(1)) begin
          sr_n = {1'b0, mem[adr_n]}; cnt_n = '0; st_n = S_READ;
        end
        S_ERD: if (cnt_n == CW'(DW)) begin
          sr_n = {1'b0, {DW{1'b1}}}; cnt_n = '0; st_n = S_WRITE;
        end
        default: ;
      endcase
    end else if (sk_fall && st_n == S_READ) begin
      sr_n  = {sr_n[SW-2:0], 1'b0};
      cnt_n = cnt_n + 1'b1;
      if (cnt_n == CW'(DW)) begin
        cnt_n = '0; st_n = S_NULL;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_NULL; sr <= '1; cnt <= '0; op <= '0; adr <= '0;
      wen <= 1'b0; cs_q <= 1'b0; sk_q <= 1'b0;
    end else begin
      st <= st_n; sr <= sr_n; cnt <= cnt_n; op <= op_n; adr <= adr_n; wen <= wen_n;
      if (wr_en) begin
        cs_q <= cs_in;
        sk_q <= sk_in;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '1;
    end else if (clr_all) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '1;
    end else if (fill_all) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= sr_n[DW-1:0];
    end else if (commit) begin
      mem[adr] <= sr[DW-1:0];
    end
  end
endmodule

// File: rtl/serprom_emu_chk.sv
module serprom_emu_chk #(
  parameter int CS_BIT = 7,
  parameter int SK_BIT = 6,
  parameter int DI_BIT = 1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic [3:0] st,
  input logic       wen,
  input logic       cs_q,
  input logic       sk_q
);
  localparam logic [3:0] C_NULL = 4'd0, C_IDLE = 4'd1, C_RDD = 4'd6,
                         C_READ = 4'd8, C_WRITE = 4'd9;

  wire cs_up = wr_en && wr_data[CS_BIT] && !cs_q;
  wire sk_up = wr_en && wr_data[SK_BIT] && !sk_q;

  a_r1_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rd_data) && $stable(st));

  a_r4_enable_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(wen));

  a_r5_commit_to_null: assert property (@(posedge clk) disable iff (!rst_n)
    cs_up && st == C_WRITE |=> st == C_NULL && rd_data[0]);

  a_r11_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cs_up && st != C_WRITE && !sk_up |=> st == C_IDLE);

  a_r6_dummy_zero: assert property (@(posedge clk) disable iff (!rst_n)
    st == C_READ && $past(st) == C_RDD |-> rd_data[0] == 1'b0);

  a_r3_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    st == C_IDLE && wr_en && !cs_up && !wr_data[DI_BIT] |=> st == C_IDLE);
endmodule

bind serprom_emu serprom_emu_chk #(.CS_BIT(CS_BIT), .SK_BIT(SK_BIT), .DI_BIT(DI_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
  .st(st), .wen(wen), .cs_q(cs_q), .sk_q(sk_q)
);

// File: tb/serprom_emu_bench.sv
module serprom_emu_bench;
  localparam int TCLK = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [15:0] em [256];
  bit en = 1'b0;

  serprom_emu u_serprom_emu (.clk(clk), .rst_n(rst_n), .wr_en(wr_en),
                             .wr_data(wr_data), .rd_data(rd_data));

  always #(TCLK/2) clk = ~clk;

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input bit cs, input bit sk, input bit d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = {cs, sk, 4'b0000, d, 1'b0};
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bitclk(input bit d);
    wr(1, 0, d); wr(1, 1, d);
  endtask

  task automatic send(input logic [15:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) bitclk(v[i]);
  endtask

  task automatic hdr(input logic [1:0] cmd, input logic [7:0] a);
    wr(0, 0, 0); wr(1, 0, 0);
    bitclk(1); send(16'(cmd), 2); send(16'(a), 8);
  endtask

  task automatic finish_op;
    wr(0, 0, 0); wr(1, 0, 0); wr(0, 0, 0);
  endtask

  task automatic do_write(input logic [7:0] a, input logic [15:0] d);
    hdr(2'd1, a); send(d, 16); finish_op();
    if (en) em[a] = d;
  endtask

  task automatic do_erase(input logic [7:0] a);
    hdr(2'd3, a); send(16'h0, 16); finish_op();
    if (en) em[a] = 16'hFFFF;
  endtask

  task automatic do_wral(input logic [15:0] d);
    hdr(2'd0, 8'h40); send(d, 16); finish_op();
    if (en) for (int i = 0; i < 256; i++) em[i] = d;
  endtask

  task automatic do_eral;
    hdr(2'd0, 8'h80); send(16'h1234, 16); finish_op();
    if (en) for (int i = 0; i < 256; i++) em[i] = 16'hFFFF;
  endtask

  task automatic do_ewen;
    hdr(2'd0, 8'hC5); wr(0, 0, 0); en = 1'b1;
  endtask

  task automatic do_ewds;
    hdr(2'd0, 8'h2A); wr(0, 0, 0); en = 1'b0;
  endtask

  task automatic do_read(input logic [7:0] a, output logic [15:0] w, output logic dz);
    hdr(2'd2, a); bitclk(0);
    dz = rd_data[0];
    w = '0;
    for (int i = 0; i < 16; i++) begin
      wr(1, 1, 0); wr(1, 0, 0);
      w = {w[14:0], rd_data[0]};
    end
    wr(0, 0, 0);
  endtask

  task automatic sweep(input string tag, input int stride);
    logic [15:0] w; logic dz;
    for (int a = 0; a < 256; a += stride) begin
      do_read(8'(a), w, dz);
      check(tag, w, em[a]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] w; logic dz;
    for (int i = 0; i < 256; i++) em[i] = 16'hFFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 R1 reset data-out byte", 16'(rd_data), 16'h0001);
    sweep("R2 reset words", 4);

    do_read(8'h11, w, dz);
    check("R6 dummy zero", 16'(dz), 16'h0);
    check("R6 data-out holds last bit", 16'(rd_data), 16'(em[8'h11][0]));
    check("R1 upper read bits zero", 16'(rd_data[7:1]), 16'h0);

    do_write(8'h05, 16'h1234);
    do_read(8'h05, w, dz);
    check("R10 write while disabled", w, 16'hFFFF);

    do_ewen();
    for (int a = 0; a < 256; a++) do_write(8'(a), 16'(a * 16'h0101) ^ 16'h5A3C);
    sweep("R5 R4 write sweep", 1);

    do_read(8'h3E, w, dz);
    check("R6 last bit held", 16'(rd_data), 16'(w[0]));

    do_erase(8'h07);
    do_read(8'h07, w, dz);
    check("R7 erase word", w, 16'hFFFF);
    do_read(8'h08, w, dz);
    check("R7 neighbour untouched", w, em[8]);

    wr(0, 0, 0); wr(1, 0, 0);
    bitclk(0); bitclk(0); bitclk(1); send(16'd1, 2); send(16'd33, 8);
    send(16'hC0DE, 16); finish_op();
    em[33] = 16'hC0DE;
    do_read(8'd33, w, dz);
    check("R3 zeros before start ignored", w, 16'hC0DE);

    hdr(2'd1, 8'd20); send(16'hAB, 8);
    wr(0, 0, 0); wr(1, 0, 0); wr(0, 0, 0);
    do_read(8'd20, w, dz);
    check("R11 aborted write", w, em[20]);

    do_ewds();
    do_erase(8'h09);
    do_read(8'h09, w, dz);
    check("R10 erase while disabled", w, em[9]);
    do_wral(16'h1111);
    do_eral();
    sweep("R10 fill and clear while disabled", 16);

    do_ewen();
    do_wral(16'hBEEF);
    sweep("R8 write-all", 8);
    do_eral();
    sweep("R9 erase-all", 8);
    do_write(8'hA0, 16'h0F0F);
    do_read(8'hA0, w, dz);
    check("R5 write after erase-all", w, 16'h0F0F);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule